// File: doc/BRIEF.md
# Coprocessor Instruction Availability Checker

This block keeps the few control flags that decide whether floating-point, multimedia and vector instructions may run, and judges each decoded instruction against them. Software loads the flags through a one-cycle write port. The decoder presents an instruction class together with a valid strobe. One cycle later the block returns a result: the instruction may execute, it raises a device-not-available fault, or it raises an invalid-opcode fault. The three flags do not affect every class in the same way. WAIT instructions look only at the monitor and task-switched flags. Multimedia and vector instructions give an invalid-opcode fault rather than a device fault. A group of housekeeping vector instructions ignores the emulation flag completely.

The block also reports the processor mode from two of the stored bits. Protected mode follows the protection-enable bit. Paging is reported only when the paging bit and protection-enable are both set. The block does not decode instructions, deliver exceptions or contain any arithmetic.

Top module: `coproc_avail_check`

## Requirements
- R1: A write with `wr_en` high stores protection-enable from bit 0, monitor from bit 1, emulation from bit 2, task-switched from bit 3 and paging from bit `PG_BIT` (default 31) of `wr_data`. All other bits of `wr_data` have no effect.
- R2: After reset all five flags are clear, so every instruction class executes and `prot_mode` and `paging_on` are low.
- R3: `res_valid` goes high exactly one cycle after `ins_valid`, and is low otherwise. `res_code` is 00 for execute, 01 for device-not-available and 10 for invalid-opcode. It is 00 whenever `res_valid` is low and is never 11.
- R4: Class 0 (x87 arithmetic) gives device-not-available when emulation is set. With emulation clear it gives device-not-available when task-switched is set, and executes otherwise.
- R5: Class 1 (WAIT) gives device-not-available only when monitor and task-switched are both set. Emulation has no effect on it.
- R6: Class 2 (MMX) and class 3 (vector extension) give invalid-opcode when emulation is set and execute otherwise. Monitor and task-switched have no effect on them.
- R7: Class 4 (exempt vector group: pause, prefetch, fences, non-temporal integer store, cache-line flush, CRC, population count) always executes. Unassigned classes 5 to 7 also execute.
- R8: When a flag write and an instruction check happen in the same cycle, the check uses the flags as they were before the write. The new values apply from the next instruction on.
- R9: `prot_mode` equals the stored protection-enable bit. `paging_on` is high only when protection-enable and paging are both stored set. Both outputs change in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Flag register write strobe |
| wr_data | input | CTRL_W | Control word to be written |
| ins_valid | input | 1 | Instruction class is valid this cycle |
| ins_cls | input | CLS_W | Decoded instruction class |
| res_valid | output | 1 | Result is valid |
| res_code | output | 2 | 00 execute, 01 device-not-available, 10 invalid-opcode |
| prot_mode | output | 1 | Protected mode selected |
| paging_on | output | 1 | Paging enabled |

## Verification
On every cycle the assertions check the following properties:
- The one-cycle result latency, and that the result is 00 when idle.
- That code 11 never appears.
- That the exempt group always executes.
- That an x87 instruction faults whenever emulation is set.
- That WAIT ignores emulation.
- That paging is never reported without protected mode.

The full decision table across all eight flag combinations and every class can only be shown by the bench's sweep and random scenarios. The same holds for the write-versus-check ordering in a shared cycle and for ignored write bits. In each case the bench compares the design against a reference model of the flags.

// File: rtl/coproc_avail_check.sv
module coproc_avail_check #(
  parameter int CTRL_W = 32,
  parameter int PG_BIT = 31,
  parameter int CLS_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              ins_valid,
  input  logic [CLS_W-1:0]  ins_cls,
  output logic              res_valid,
  output logic [1:0]        res_code,
  output logic              prot_mode,
  output logic              paging_on
);
  localparam int PE_BIT = 0;
  localparam int MP_BIT = 1;
  localparam int EM_BIT = 2;
  localparam int TS_BIT = 3;

  localparam logic [CLS_W-1:0] C_X87    = CLS_W'(0);
  localparam logic [CLS_W-1:0] C_WAIT   = CLS_W'(1);
  localparam logic [CLS_W-1:0] C_MMX    = CLS_W'(2);
  localparam logic [CLS_W-1:0] C_SIMD   = CLS_W'(3);

  localparam logic [1:0] R_EXEC = 2'b00;
  localparam logic [1:0] R_NM   = 2'b01;
  localparam logic [1:0] R_UD   = 2'b10;

  logic pe_q, mp_q, em_q, ts_q, pg_q;
  logic [1:0] verdict;
  logic unused_bits;

  assign unused_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pe_q <= 1'b0;
      mp_q <= 1'b0;
      em_q <= 1'b0;
      ts_q <= 1'b0;
      pg_q <= 1'b0;
    end else if (wr_en) begin
      pe_q <= wr_data[PE_BIT];
      mp_q <= wr_data[MP_BIT];
      em_q <= wr_data[EM_BIT];
      ts_q <= wr_data[TS_BIT];
      pg_q <= wr_data[PG_BIT];
    end
  end

  always_comb begin
    verdict = R_EXEC;
    case (ins_cls)
      C_X87:  if (em_q || ts_q) verdict = R_NM;
      C_WAIT: if (mp_q && ts_q) verdict = R_NM;
      C_MMX,
      C_SIMD: if (em_q) verdict = R_UD;
      default: verdict = R_EXEC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_code  <= R_EXEC;
    end else begin
      res_valid <= ins_valid;
      res_code  <= ins_valid ? verdict : R_EXEC;
    end
  end

  assign prot_mode = pe_q;
  assign paging_on = pe_q & pg_q;
endmodule

module coproc_avail_check_sva #(
  parameter int CLS_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic [CLS_W-1:0] ins_cls,
  input logic             res_valid,
  input logic [1:0]       res_code,
  input logic             em_q,
  input logic             prot_mode,
  input logic             paging_on
);
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |=> res_valid);
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> (!res_valid && res_code == 2'b00));
  p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_code != 2'b11);
  p_x87_em_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_cls == CLS_W'(0) && em_q) |=> res_code == 2'b01);
  p_wait_no_ud_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_cls == CLS_W'(1)) |=> res_code != 2'b10);
  p_exempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_cls == CLS_W'(4)) |=> res_code == 2'b00);
  p_paging_r9: assert property (@(posedge clk) disable iff (!rst_n)
    paging_on |-> prot_mode);
endmodule

bind coproc_avail_check coproc_avail_check_sva #(.CLS_W(CLS_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_cls(ins_cls),
  .res_valid(res_valid), .res_code(res_code), .em_q(em_q),
  .prot_mode(prot_mode), .paging_on(paging_on)
);

// File: tb/sim_coproc_avail_check.sv
`timescale 1ns/1ps
module sim_coproc_avail_check;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic ins_valid = 1'b0;
  logic [2:0] ins_cls = '0;
  logic res_valid;
  logic [1:0] res_code;
  logic prot_mode, paging_on;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic m_pe = 0, m_mp = 0, m_em = 0, m_ts = 0, m_pg = 0;

  always #2 clk = ~clk;

  coproc_avail_check u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ins_valid(ins_valid), .ins_cls(ins_cls), .res_valid(res_valid),
    .res_code(res_code), .prot_mode(prot_mode), .paging_on(paging_on)
  );

  function automatic logic [1:0] ref_code(input logic [2:0] c, input logic em,
                                          input logic mp, input logic ts);
    case (c)
      3'd0: return (em || ts) ? 2'b01 : 2'b00;
      3'd1: return (mp && ts) ? 2'b01 : 2'b00;
      3'd2, 3'd3: return em ? 2'b10 : 2'b00;
      default: return 2'b00;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2, 3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [31:0] wd, input logic iv,
                      input logic [2:0] c, input string tag);
    logic [1:0] exp;
    exp = iv ? ref_code(c, m_em, m_mp, m_ts) : 2'b00;
    wr_en = we; wr_data = wd; ins_valid = iv; ins_cls = c;
    @(posedge clk);
    if (we) begin
      m_pe = wd[0]; m_mp = wd[1]; m_em = wd[2]; m_ts = wd[3]; m_pg = wd[31];
    end
    @(negedge clk);
    wr_en = 1'b0; ins_valid = 1'b0;
    chk(res_valid == iv, "R3 valid", res_valid, iv);
    chk(res_code == exp, iv ? {req_of(c), tag} : {"R3 idle", tag}, res_code, exp);
    chk(prot_mode == m_pe, "R9 prot", prot_mode, m_pe);
    chk(paging_on == (m_pe & m_pg), "R9 paging", paging_on, m_pe & m_pg);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(res_valid == 0 && res_code == 0, "R2 reset result", res_code, 0);
    chk(prot_mode == 0 && paging_on == 0, "R2 reset mode", prot_mode, 0);
    for (int c = 0; c < 8; c++) step(0, '0, 1, 3'(c), " R2");

    step(1, 32'h7FFF_FFF0, 0, 3'd0, " R1");
    step(0, '0, 1, 3'd0, " R1");
    step(0, '0, 1, 3'd2, " R1");
    step(1, 32'h8000_0000, 0, 3'd0, " R1");
    step(1, 32'h8000_0001, 0, 3'd0, " R1");

    for (int f = 0; f < 8; f++) begin
      logic [31:0] w;
      w = {1'($urandom), 27'd0, f[0], f[2], f[1], 1'($urandom)};
      step(1, w, 0, 3'd0, " sweep");
      for (int c = 0; c < 8; c++) step(0, '0, 1, 3'(c), " sweep");
    end

    step(1, 32'h0, 0, 3'd0, " R8");
    step(1, 32'h4, 1, 3'd0, " R8");
    step(0, '0, 1, 3'd0, " R8");
    step(1, 32'h0, 1, 3'd3, " R8");
    step(0, '0, 1, 3'd3, " R8");
    step(1, 32'hA, 1, 3'd1, " R8");
    step(0, '0, 1, 3'd1, " R8");

    for (int i = 0; i < 600; i++)
      step(1'($urandom % 3 == 0), $urandom, 1'($urandom % 4 != 0), 3'($urandom), " rand");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule